// File: doc/BRIEF.md
# Grouped GPIO Interrupt Status Aggregator

This block gathers the interrupt-status and wake-status flags of a large bank of GPIO pins into one compact summary. It drives a single interrupt line toward the upstream interrupt controller. Pins are taken four at a time, and each group of four consecutive pins owns one summary bit. The 46 summary bits are presented as two 32-bit words. The low word holds groups 0 to 31, and the high word holds groups 32 to 45, with every remaining bit fixed at zero. Software reads both words to find which groups need attention, and then looks at the individual pins of those groups.

The upstream line follows an arm-and-fire scheme. While the line is armed, any set summary bit raises the line on the next clock edge, and the line then stays high. No acknowledge is needed before the handler runs. Once software has finished servicing, it writes an end-of-interrupt command to the control word. That write drops the line and re-arms it. If any summary bit is still set when the line is re-armed, the line rises again one cycle later, so no pending source is lost. Per-pin detection and debounce sit in front of this block and are not part of it.

Top module: `gpio_int_aggregator`

## Requirements
- R1: Summary bit g is set exactly when at least one of the interrupt or wake flags of pins 4g, 4g+1, 4g+2 and 4g+3 is set. Groups 0 to 31 appear in `summary_lo` bit g, and groups 32 to 45 appear in `summary_hi` bit g-32. The summary follows the pin flags in the same cycle, with no register in between.
- R2: Bits 14 to 31 of `summary_hi` are always zero.
- R3: A register read returns `summary_lo` at byte address 0x0 and `summary_hi` at byte address 0x4. The control word at 0x8 and every other address read as zero. Read data is combinational from `reg_addr`.
- R4: While `rst` is high, and on the first cycle after it, `irq_out` is low and the line is armed.
- R5: When the line is armed and any summary bit is set at a rising clock edge, `irq_out` is high after that edge. No bus access is needed for this.
- R6: Once high, `irq_out` stays high until an end-of-interrupt write, even if all pin flags clear.
- R7: An end-of-interrupt write is a write with `reg_wr_en` high, `reg_addr` equal to 0x8 and `reg_wdata` bit 0 set. When the line is high, this write drives `irq_out` low after the edge that takes the write, and it re-arms the line.
- R8: If summary bits are still set after an end-of-interrupt write, `irq_out` goes high again on the following edge. The result is a single low cycle.
- R9: The following writes leave `irq_out` unchanged: a write to 0x8 with bit 0 clear, a write to any other address, and an end-of-interrupt write while the line is already armed. In the last case, a later summary bit still fires the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_int_sts | input | 184 | Per-pin interrupt status flags |
| pin_wake_sts | input | 184 | Per-pin wake status flags |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| summary_lo | output | 32 | Summary bits for groups 0 to 31 |
| summary_hi | output | 32 | Summary bits for groups 32 to 45, upper bits zero |
| irq_out | output | 1 | Upstream interrupt line |

## Verification
The only internal state is the arm flag, and a wrong arm flag shows on `irq_out` at the next clock edge. A lost arm shows as a line that stays low while summary bits are set. A stuck arm shows as a line that drops without an end-of-interrupt write, or that fails to rise again after one. A wrong group mapping needs no clock to show: it appears at once in the summary words and in the read data. The bench therefore drives one pin at a time, including the group boundaries between the two words, and checks the line one edge after each stimulus.

// File: rtl/gpio_agg_pkg.sv
package gpio_agg_pkg;

    localparam int REG_W   = 32;
    localparam int EOI_BIT = 0;

    typedef enum logic {
        ARM_READY = 1'b0,
        ARM_FIRED = 1'b1
    } arm_state_e;

    typedef struct packed {
        logic [REG_W-1:0] lo;
        logic [REG_W-1:0] hi;
    } summary_words_t;

    function automatic logic any_flag(input logic [3:0] int_f, input logic [3:0] wake_f);
        return (|int_f) | (|wake_f);
    endfunction

endpackage

// File: rtl/gpio_grp_reduce.sv
module gpio_grp_reduce #(
    parameter int PIN_COUNT  = 184,
    parameter int GROUP_SIZE = 4,
    localparam int GROUP_COUNT = PIN_COUNT / GROUP_SIZE
) (
    input  logic [PIN_COUNT-1:0]   int_sts,
    input  logic [PIN_COUNT-1:0]   wake_sts,
    output logic [GROUP_COUNT-1:0] grp_hit
);
    import gpio_agg_pkg::*;

    for (genvar g = 0; g < GROUP_COUNT; g++) begin : g_grp
        if (GROUP_SIZE == 4) begin : g_quad
            assign grp_hit[g] = any_flag(int_sts[g*4 +: 4], wake_sts[g*4 +: 4]);
        end else begin : g_generic
            assign grp_hit[g] = (|int_sts[g*GROUP_SIZE +: GROUP_SIZE])
                              | (|wake_sts[g*GROUP_SIZE +: GROUP_SIZE]);
        end
    end

endmodule

// File: rtl/gpio_sum_view.sv
module gpio_sum_view #(
    parameter int GROUP_COUNT = 46,
    parameter int ADDR_W      = 4
) (
    input  logic [GROUP_COUNT-1:0] grp_hit,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [31:0]            summary_lo,
    output logic [31:0]            summary_hi,
    output logic [31:0]            rd_data
);
    import gpio_agg_pkg::*;

    localparam logic [ADDR_W-1:0] ADDR_LO = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_HI = ADDR_W'(4);

    summary_words_t words;
    logic [2*REG_W-1:0] padded;

    always_comb begin
        padded = '0;
        padded[GROUP_COUNT-1:0] = grp_hit;
        words.lo = padded[REG_W-1:0];
        words.hi = padded[2*REG_W-1:REG_W];
    end

    assign summary_lo = words.lo;
    assign summary_hi = words.hi;

    always_comb begin
        unique case (rd_addr)
            ADDR_LO: rd_data = words.lo;
            ADDR_HI: rd_data = words.hi;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_arm.sv
module gpio_irq_arm (
    input  logic clk,
    input  logic rst,
    input  logic any_hit,
    input  logic eoi_req,
    output logic irq_out
);
    import gpio_agg_pkg::*;

    arm_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARM_READY;
        end else begin
            unique case (state_q)
                ARM_READY: if (any_hit) state_q <= ARM_FIRED;
                ARM_FIRED: if (eoi_req) state_q <= ARM_READY;
                default:   state_q <= ARM_READY;
            endcase
        end
    end

    assign irq_out = (state_q == ARM_FIRED);

endmodule

// File: rtl/gpio_int_aggregator.sv
module gpio_int_aggregator #(
    parameter int PIN_COUNT  = 184,
    parameter int GROUP_SIZE = 4,
    parameter int ADDR_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PIN_COUNT-1:0] pin_int_sts,
    input  logic [PIN_COUNT-1:0] pin_wake_sts,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [31:0]          summary_lo,
    output logic [31:0]          summary_hi,
    output logic                 irq_out
);
    import gpio_agg_pkg::*;

    localparam int GROUP_COUNT = PIN_COUNT / GROUP_SIZE;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(8);

    logic [GROUP_COUNT-1:0] grp_hit;
    logic eoi_req;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign eoi_req = reg_wr_en && (reg_addr == ADDR_CTRL) && reg_wdata[EOI_BIT];

    gpio_grp_reduce #(
        .PIN_COUNT (PIN_COUNT),
        .GROUP_SIZE(GROUP_SIZE)
    ) u_reduce (
        .int_sts (pin_int_sts),
        .wake_sts(pin_wake_sts),
        .grp_hit (grp_hit)
    );

    gpio_sum_view #(
        .GROUP_COUNT(GROUP_COUNT),
        .ADDR_W     (ADDR_W)
    ) u_view (
        .grp_hit   (grp_hit),
        .rd_addr   (reg_addr),
        .summary_lo(summary_lo),
        .summary_hi(summary_hi),
        .rd_data   (reg_rdata)
    );

    gpio_irq_arm u_arm (
        .clk    (clk),
        .rst    (rst),
        .any_hit(|grp_hit),
        .eoi_req(eoi_req),
        .irq_out(irq_out)
    );

endmodule

// File: rtl/gpio_int_aggregator_chk.sv
module gpio_int_aggregator_chk #(
    parameter int PIN_COUNT = 184,
    parameter int ADDR_W    = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [PIN_COUNT-1:0] pin_int_sts,
    input logic [PIN_COUNT-1:0] pin_wake_sts,
    input logic                 reg_wr_en,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [31:0]          reg_wdata,
    input logic [31:0]          summary_lo,
    input logic [31:0]          summary_hi,
    input logic                 irq_out
);
    logic eoi_seen;
    logic any_sum;
    logic any_pin;

    assign eoi_seen = reg_wr_en && (reg_addr == ADDR_W'(8)) && reg_wdata[0];
    assign any_sum  = (|summary_lo) | (|summary_hi);
    assign any_pin  = (|pin_int_sts) | (|pin_wake_sts);

    p_sum_matches_pins_r1: assert property (@(posedge clk) disable iff (rst)
        any_sum == any_pin);

    p_hi_pad_zero_r2: assert property (@(posedge clk) disable iff (rst)
        summary_hi[31:14] == '0);

    p_fire_when_armed_r5: assert property (@(posedge clk) disable iff (rst)
        (!irq_out && any_sum) |=> irq_out);

    p_hold_until_eoi_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_out && !eoi_seen) |=> irq_out);

    p_eoi_drops_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_out && eoi_seen) |=> !irq_out);

    p_rise_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> $past(any_sum));

    p_reset_low_r4: assert property (@(posedge clk)
        $past(rst) |-> !irq_out);

endmodule

bind gpio_int_aggregator gpio_int_aggregator_chk #(
    .PIN_COUNT(PIN_COUNT),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pin_int_sts (pin_int_sts),
    .pin_wake_sts(pin_wake_sts),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .summary_lo  (summary_lo),
    .summary_hi  (summary_hi),
    .irq_out     (irq_out)
);

// File: tb/gpio_int_aggregator_tb.sv
module gpio_int_aggregator_tb_top;

    localparam int PINS = 184;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PINS-1:0] int_v = '0;
    logic [PINS-1:0] wake_v = '0;
    logic            wr_en = 1'b0;
    logic [3:0]      addr = 4'h0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [31:0]     sum_lo;
    logic [31:0]     sum_hi;
    logic            irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpio_int_aggregator dut_i (
        .clk         (clk),
        .rst         (rst),
        .pin_int_sts (int_v),
        .pin_wake_sts(wake_v),
        .reg_wr_en   (wr_en),
        .reg_addr    (addr),
        .reg_wdata   (wdata),
        .reg_rdata   (rdata),
        .summary_lo  (sum_lo),
        .summary_hi  (sum_hi),
        .irq_out     (irq)
    );

    // Each entry: bit 8 selects the wake flag, bits 7:0 give the pin number.
    localparam logic [8:0] VEC_TBL [8] = '{
        9'h000, 9'h003, 9'h105, 9'h07F, 9'h080, 9'h1B7, 9'h064, 9'h140
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        addr  = 4'h0;
        wdata = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] exp64;
        // R4: reset state
        @(negedge clk);
        chk("R4 irq in reset", {31'b0, irq}, 32'h0);
        chk("R1 idle summary", sum_lo, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R4 irq after reset", {31'b0, irq}, 32'h0);

        // Table walk: one pin at a time
        for (int k = 0; k < 8; k++) begin
            int pin;
            pin = int'(VEC_TBL[k][7:0]);
            exp64 = 64'd1 << (pin / 4);
            if (VEC_TBL[k][8]) wake_v[pin] = 1'b1;
            else               int_v[pin]  = 1'b1;
            #1;
            chk("R1 summary_lo", sum_lo, exp64[31:0]);
            chk("R1 summary_hi", sum_hi, exp64[63:32]);
            addr = 4'h0; #1;
            chk("R3 read low", rdata, exp64[31:0]);
            addr = 4'h4; #1;
            chk("R3 read high", rdata, exp64[63:32]);
            addr = 4'h0;
            @(negedge clk);
            chk("R5 irq fires", {31'b0, irq}, 32'h1);
            int_v  = '0;
            wake_v = '0;
            @(negedge clk);
            chk("R6 irq held", {31'b0, irq}, 32'h1);
            bus_write(4'h8, 32'h1);
            chk("R7 eoi drops", {31'b0, irq}, 32'h0);
            @(negedge clk);
            chk("R7 stays low", {31'b0, irq}, 32'h0);
        end

        // R2: all pins set
        int_v = '1;
        #1;
        chk("R2 high pad", sum_hi, 32'h0000_3FFF);
        chk("R1 all low", sum_lo, 32'hFFFF_FFFF);
        addr = 4'h8; #1;
        chk("R3 ctrl reads zero", rdata, 32'h0);
        addr = 4'hC; #1;
        chk("R3 unmapped reads zero", rdata, 32'h0);
        addr = 4'h0;
        int_v = '0;
        @(negedge clk);

        // R8: status still set across EOI
        wake_v[10] = 1'b1;
        @(negedge clk);
        chk("R8 fired", {31'b0, irq}, 32'h1);
        bus_write(4'h8, 32'h1);
        chk("R8 low gap", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R8 refires", {31'b0, irq}, 32'h1);
        wake_v = '0;
        bus_write(4'h8, 32'h1);
        @(negedge clk);
        chk("R8 settled", {31'b0, irq}, 32'h0);

        // R9: writes without effect
        int_v[50] = 1'b1;
        @(negedge clk);
        int_v = '0;
        chk("R9 setup fired", {31'b0, irq}, 32'h1);
        bus_write(4'h8, 32'h0000_0002);
        chk("R9 ctrl bit0 clear", {31'b0, irq}, 32'h1);
        bus_write(4'h0, 32'h1);
        chk("R9 write addr0", {31'b0, irq}, 32'h1);
        bus_write(4'h4, 32'h1);
        chk("R9 write addr4", {31'b0, irq}, 32'h1);
        bus_write(4'h8, 32'h1);
        chk("R7 eoi after noise", {31'b0, irq}, 32'h0);
        bus_write(4'h8, 32'h1);
        chk("R9 eoi while armed", {31'b0, irq}, 32'h0);
        int_v[183] = 1'b1;
        @(negedge clk);
        chk("R9 still armed", {31'b0, irq}, 32'h1);

        // R4: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        chk("R4 reset clears irq", {31'b0, irq}, 32'h0);
        int_v = '0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R4 idle after reset", {31'b0, irq}, 32'h0);

        finish_run();
    end

endmodule